// File: doc/BRIEF.md
# Terminated Message Streamer

This block holds a short fixed character string and sends it over a serial line, one byte per 8N1 frame. A one-clock start pulse begins a run at the first character. The block loads each character into an internal frame serializer only after the previous frame has fully left the line. A baud-tick divider paces the serializer. When the loaded character is the line-feed terminator (8'h0A), that character is still sent in full. The run then ends, the line returns to the idle level, and a one-clock finished pulse is raised.

The character being handed to the serializer and its load strobe are brought out for observation, together with a busy flag. The message text and its length are parameters, and so is the number of system clocks per line bit (1085 gives 115200 baud from a 125 MHz clock). If the message contains no terminator, the run ends after the last slot.

Top module: `msg_streamer_top`

## Requirements
- R1: Each character goes out as one frame: a start bit of 0, then the eight data bits with bit 0 first, then a stop bit of 1.
- R2: Every line bit, start and stop included, lasts exactly CLKS_PER_BIT clock cycles.
- R3: `char_load_o` is a one-cycle strobe with the character on `char_o`. It is raised only while the serializer is free, so each frame completes before the next one starts. There is exactly one frame per strobe.
- R4: Characters are sent in message order, beginning at slot 0. Slot i is bits [(MSG_LEN-1-i)*8 +: 8] of `MSG`, so the first character of a string literal comes first.
- R5: A character equal to 8'h0A is transmitted completely, and it is the last character of the run.
- R6: Once a run has ended, `tx_o` stays at 1 and no further strobe appears until the next start pulse.
- R7: `finished_o` is high for exactly one cycle, on the clock after the serializer reports the end of the last stop bit. `busy_o` falls in that same cycle.
- R8: A start pulse while `busy_o` is 1 has no effect: the character sequence and the count of finished pulses are unchanged.
- R9: A start pulse while idle begins a new run from slot 0.
- R10: If no slot holds 8'h0A, the run sends all MSG_LEN characters and then ends.
- R11: While `rst` is high, `tx_o` is 1, and `busy_o`, `finished_o` and `char_load_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to send the message |
| tx_o | output | 1 | Serial line, idle high |
| char_o | output | 8 | Character handed to the serializer |
| char_load_o | output | 1 | One-cycle strobe qualifying `char_o` |
| busy_o | output | 1 | A run is in progress |
| finished_o | output | 1 | One-cycle pulse at the end of a run |

## Verification
The bench decodes the serial line at mid-bit. A design that stopped the moment it saw the terminator would show one frame too few, and a design that ignored the terminator would let the character after it leak out. Extra start pulses are fired at random points during a run; a design that restarted on them would repeat the first character and raise a second finished pulse. Measuring the first start bit and the distance from the last frame's start to `finished_o` exposes an off-by-one in the bit divider or in the end-of-run handshake. A second instance holding a message with no terminator checks that the run ends after the last slot rather than wrapping around to slot 0.

// File: rtl/msg_stream_pkg.sv
package msg_stream_pkg;
  localparam logic [7:0] TERM_BYTE = 8'h0A;
  localparam logic LINE_IDLE = 1'b1;
  localparam int FRAME_BITS = 10;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_FETCH,
    SQ_SEND
  } sq_state_t;
endpackage

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int CLKS_PER_BIT = 1085
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = $clog2(CLKS_PER_BIT + 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(CLKS_PER_BIT - 1));

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/frame_serializer.sv
module frame_serializer
  import msg_stream_pkg::*;
#(
  parameter int CLKS_PER_BIT = 1085
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [7:0] data,
  output logic       tx,
  output logic       busy,
  output logic       done
);
  localparam int BW = $clog2(FRAME_BITS);

  logic          active;
  logic          tick;
  logic [8:0]    shreg;
  logic [BW-1:0] bitn;

  baud_tick_gen #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tick (
    .clk (clk),
    .rst (rst),
    .run (active),
    .tick(tick)
  );

  assign busy = active;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      tx     <= LINE_IDLE;
      shreg  <= '1;
      bitn   <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (load) begin
          active <= 1'b1;
          tx     <= 1'b0;
          shreg  <= {1'b1, data};
          bitn   <= '0;
        end
      end else if (tick) begin
        if (bitn == BW'(FRAME_BITS - 1)) begin
          active <= 1'b0;
          done   <= 1'b1;
          tx     <= LINE_IDLE;
        end else begin
          tx    <= shreg[0];
          shreg <= {1'b1, shreg[8:1]};
          bitn  <= bitn + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/msg_sequencer.sv
module msg_sequencer
  import msg_stream_pkg::*;
#(
  parameter int                 MSG_LEN = 8,
  parameter logic [MSG_LEN*8-1:0] MSG   = "Online\n#"
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       ser_done,
  output logic [7:0] char_out,
  output logic       char_load,
  output logic       busy,
  output logic       finished
);
  localparam int IDX_W = (MSG_LEN > 1) ? $clog2(MSG_LEN) : 1;

  logic [7:0]       rom [MSG_LEN];
  logic [IDX_W-1:0] idx;
  logic             stop_after;
  sq_state_t        state;

  for (genvar g = 0; g < MSG_LEN; g++) begin : g_rom
    assign rom[g] = MSG[(MSG_LEN-1-g)*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SQ_IDLE;
      idx        <= '0;
      stop_after <= 1'b0;
      char_out   <= '0;
      char_load  <= 1'b0;
      busy       <= 1'b0;
      finished   <= 1'b0;
    end else begin
      char_load <= 1'b0;
      finished  <= 1'b0;
      case (state)
        SQ_IDLE: begin
          if (start) begin
            idx   <= '0;
            busy  <= 1'b1;
            state <= SQ_FETCH;
          end
        end
        SQ_FETCH: begin
          char_out   <= rom[idx];
          char_load  <= 1'b1;
          stop_after <= (rom[idx] == TERM_BYTE) ||
                        (idx == IDX_W'(MSG_LEN - 1));
          state      <= SQ_SEND;
        end
        SQ_SEND: begin
          if (ser_done) begin
            if (stop_after) begin
              busy     <= 1'b0;
              finished <= 1'b1;
              idx      <= '0;
              state    <= SQ_IDLE;
            end else begin
              idx   <= idx + 1'b1;
              state <= SQ_FETCH;
            end
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/msg_streamer_top.sv
module msg_streamer_top #(
  parameter int                   CLKS_PER_BIT = 1085,
  parameter int                   MSG_LEN      = 8,
  parameter logic [MSG_LEN*8-1:0] MSG          = "Online\n#"
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  output logic       tx_o,
  output logic [7:0] char_o,
  output logic       char_load_o,
  output logic       busy_o,
  output logic       finished_o
);
  logic ser_busy;
  logic ser_done;

  msg_sequencer #(.MSG_LEN(MSG_LEN), .MSG(MSG)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start_i),
    .ser_done (ser_done),
    .char_out (char_o),
    .char_load(char_load_o),
    .busy     (busy_o),
    .finished (finished_o)
  );

  frame_serializer #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_ser (
    .clk (clk),
    .rst (rst),
    .load(char_load_o),
    .data(char_o),
    .tx  (tx_o),
    .busy(ser_busy),
    .done(ser_done)
  );
endmodule

// File: rtl/stream_checker.sv
module stream_checker (
  input logic       clk,
  input logic       rst,
  input logic       start_i,
  input logic       tx_o,
  input logic [7:0] char_o,
  input logic       char_load_o,
  input logic       busy_o,
  input logic       finished_o,
  input logic       ser_busy,
  input logic       ser_done
);
  assert_load_when_free_R3: assert property (@(posedge clk) disable iff (rst)
    char_load_o |-> !ser_busy);

  assert_load_single_R3: assert property (@(posedge clk) disable iff (rst)
    char_load_o |=> !char_load_o);

  assert_start_bit_R1: assert property (@(posedge clk) disable iff (rst)
    char_load_o |=> !tx_o);

  assert_idle_line_R6: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> tx_o);

  assert_no_load_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !char_load_o);

  assert_fin_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    finished_o |=> !finished_o);

  assert_fin_after_done_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(finished_o) |-> $past(ser_done) && !busy_o);

  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i && !ser_done) |=> busy_o);
endmodule

bind msg_streamer_top stream_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .tx_o       (tx_o),
  .char_o     (char_o),
  .char_load_o(char_load_o),
  .busy_o     (busy_o),
  .finished_o (finished_o),
  .ser_busy   (ser_busy),
  .ser_done   (ser_done)
);

// File: tb/tb_msg_streamer_top.sv
module frame_mon #(
  parameter int C = 4
) (
  input logic        clk,
  input logic        line,
  input logic [31:0] cyc
);
  int          cnt = 0;
  int          ferr = 0;
  int          first_low = 0;
  int          last_start = 0;
  logic [7:0]  bytes [256];

  initial begin
    logic [9:0] f;
    forever begin
      @(negedge clk);
      if (line === 1'b0) begin
        last_start = int'(cyc);
        @(negedge clk);
        f[0] = line;
        for (int b = 1; b < 10; b++) begin
          repeat (C) @(negedge clk);
          f[b] = line;
        end
        if (f[0] !== 1'b0 || f[9] !== 1'b1) ferr++;
        bytes[cnt % 256] = f[8:1];
        cnt++;
      end
    end
  end

  initial begin
    int run;
    run = 0;
    @(negedge clk);
    while (line !== 1'b0) @(negedge clk);
    while (line === 1'b0) begin
      run++;
      @(negedge clk);
    end
    first_low = run;
  end
endmodule

module tb_msg_streamer_top;
  localparam int C = 4;
  localparam logic [63:0] MSG_A = "Online\n#";
  localparam logic [63:0] MSG_B = "abcdefgh";

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start0 = 1'b0;
  logic start1 = 1'b0;
  logic tx0, tx1, ld0, ld1, busy0, busy1, fin0, fin1;
  logic [7:0] ch0, ch1;
  logic [31:0] cyc = '0;

  int checks = 0;
  int failures = 0;
  int fin_cnt0 = 0, fin_cnt1 = 0, ld_cnt0 = 0, fin_cyc0 = 0;
  logic [7:0] last_ld0 = '0;

  always #4 clk = ~clk;

  msg_streamer_top #(.CLKS_PER_BIT(C), .MSG_LEN(8), .MSG(MSG_A)) dut (
    .clk(clk), .rst(rst), .start_i(start0), .tx_o(tx0), .char_o(ch0),
    .char_load_o(ld0), .busy_o(busy0), .finished_o(fin0));

  msg_streamer_top #(.CLKS_PER_BIT(C), .MSG_LEN(8), .MSG(MSG_B)) dut_nt (
    .clk(clk), .rst(rst), .start_i(start1), .tx_o(tx1), .char_o(ch1),
    .char_load_o(ld1), .busy_o(busy1), .finished_o(fin1));

  frame_mon #(.C(C)) mon0 (.clk(clk), .line(tx0), .cyc(cyc));
  frame_mon #(.C(C)) mon1 (.clk(clk), .line(tx1), .cyc(cyc));

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst) begin
      if (fin0) begin fin_cnt0++; fin_cyc0 = int'(cyc); end
      if (fin1) fin_cnt1++;
      if (ld0) begin ld_cnt0++; last_ld0 = ch0; end
    end
  end

  function automatic logic [7:0] exp_char(input logic [63:0] m, input int i);
    return m[(7-i)*8 +: 8];
  endfunction

  function automatic int exp_len(input logic [63:0] m);
    for (int i = 0; i < 8; i++)
      if (m[(7-i)*8 +: 8] == 8'h0A) return i + 1;
    return 8;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic pulse0();
    @(negedge clk); start0 = 1'b1;
    @(negedge clk); start0 = 1'b0;
  endtask

  task automatic wait_fin0(input int n);
    int t;
    t = 0;
    while (fin_cnt0 < n && t < 5000) begin @(negedge clk); t++; end
    check(fin_cnt0 >= n, "R7", "finished pulse not seen", fin_cnt0, n);
  endtask

  task automatic check_run0(input int base, input string req);
    int n;
    n = exp_len(MSG_A);
    repeat (3) @(negedge clk);
    check(mon0.cnt - base == n, req, "frame count", mon0.cnt - base, n);
    for (int i = 0; i < n; i++)
      check(mon0.bytes[(base+i)%256] == exp_char(MSG_A, i), req, "char",
            int'(mon0.bytes[(base+i)%256]), int'(exp_char(MSG_A, i)));
  endtask

  initial begin
    #1600000;
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int base, fins, loads;
    bit hi;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    check(tx0 === 1'b1, "R11", "tx in reset", int'(tx0), 1);
    check(busy0 === 1'b0 && fin0 === 1'b0 && ld0 === 1'b0, "R11",
          "busy/fin/load in reset", int'({busy0, fin0, ld0}), 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);

    // First run on both instances
    @(negedge clk); start0 = 1'b1; start1 = 1'b1;
    @(negedge clk); start0 = 1'b0; start1 = 1'b0;
    wait_fin0(1);
    check_run0(0, "R4");
    check(mon0.ferr == 0, "R1", "framing errors", mon0.ferr, 0);
    check(mon0.first_low == C, "R2", "start bit length", mon0.first_low, C);
    check(fin_cyc0 - mon0.last_start == 10*C + 1, "R7", "finish timing",
          fin_cyc0 - mon0.last_start, 10*C + 1);
    check(last_ld0 == 8'h0A, "R5", "last loaded char", int'(last_ld0), 10);
    check(mon0.bytes[exp_len(MSG_A)-1] == 8'h0A, "R5", "terminator on line",
          int'(mon0.bytes[exp_len(MSG_A)-1]), 10);
    check(ld_cnt0 == mon0.cnt, "R3", "loads vs frames", ld_cnt0, mon0.cnt);
    check(busy0 === 1'b0, "R7", "busy after finish", int'(busy0), 0);

    // Line stays idle after the run
    loads = ld_cnt0; base = mon0.cnt; hi = 1'b1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (tx0 !== 1'b1) hi = 1'b0;
    end
    check(hi, "R6", "line idle after end", int'(hi), 1);
    check(ld_cnt0 == loads && mon0.cnt == base, "R6", "no load after end",
          ld_cnt0 - loads, 0);

    // No-terminator instance
    while (fin_cnt1 < 1) @(negedge clk);
    repeat (3) @(negedge clk);
    check(mon1.cnt == 8, "R10", "frames without terminator", mon1.cnt, 8);
    for (int i = 0; i < 8; i++)
      check(mon1.bytes[i] == exp_char(MSG_B, i), "R10", "char",
            int'(mon1.bytes[i]), int'(exp_char(MSG_B, i)));
    check(fin_cnt1 == 1, "R10", "single finish", fin_cnt1, 1);

    // Directed: start while busy
    base = mon0.cnt; fins = fin_cnt0;
    pulse0();
    repeat (30) @(negedge clk);
    check(busy0 === 1'b1, "R8", "busy mid-run", int'(busy0), 1);
    pulse0();
    wait_fin0(fins + 1);
    check_run0(base, "R8");
    repeat (80) @(negedge clk);
    check(fin_cnt0 == fins + 1, "R8", "finish count", fin_cnt0, fins + 1);

    // Random runs with stray start pulses
    for (int r = 0; r < 12; r++) begin
      int extra;
      base = mon0.cnt; fins = fin_cnt0;
      repeat ($urandom_range(0, 25)) @(negedge clk);
      pulse0();
      extra = $urandom_range(0, 3);
      for (int e = 0; e < extra; e++) begin
        repeat ($urandom_range(2, 60)) @(negedge clk);
        if (busy0 === 1'b1) pulse0();
      end
      wait_fin0(fins + 1);
      check_run0(base, "R9");
      repeat (C*12) @(negedge clk);
      check(fin_cnt0 == fins + 1, "R8", "finish count random", fin_cnt0, fins + 1);
    end
    check(mon0.ferr == 0, "R1", "framing errors overall", mon0.ferr, 0);
    check(ld_cnt0 == mon0.cnt, "R3", "loads vs frames overall", ld_cnt0, mon0.cnt);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule